// File: doc/BRIEF.md
# Multi-Port Power Sequencing Arbiter

This block decides when each of a group of power-delivery ports may switch its supply on or off. The goal is that no two ports change state in the same moment. Each port raises a turn-on request once its own detection and classification have finished, and it can raise a turn-off request. When several requests are pending, the port with the lowest index is served first. Two shared hold-off timers spread the transitions out in time. One spaces successive power-ups. The other opens a window after every shutdown, and no further shutdown may happen inside it.

An emergency-off input covers conditions such as reset, undervoltage or thermal shutdown. It drops every port at once, takes no account of the shutdown window, and keeps all ports off for as long as it is held. An optional oscillator check blocks power-up while a clock-fail input is high. For each port the block drives an enable bit. It also drives a power-good bit, which qualifies a digital output-good input over a programmable number of cycles. Last, it drives a sticky change flag that a register interface clears with a clear-on-read strobe. All timer lengths are given in clock cycles as parameters.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, every bit of `pwr_en`, `pgood` and `pwr_chg` is 0.
- R2: A port whose `on_req` bit is high, whose `off_req` bit is low and that is not powered gets its `pwr_en` bit set on the next clock edge, provided no block applies.
- R3: Bit 0 stands for port 1. When several ports are eligible in the same cycle, only the lowest-indexed one switches on that edge.
- R4: After any power-up, no other port powers up during the next ON_HOLD_CYC edges. The earliest further power-up happens ON_HOLD_CYC+1 edges after the first one.
- R5: When `auto_chk_en` is 1 and `osc_fail` is 1, no port powers up. When `auto_chk_en` is 0, `osc_fail` has no effect.
- R6: A powered port whose `off_req` bit is high has its `pwr_en` bit cleared on the next edge. An unpowered port with both `on_req` and `off_req` high stays off.
- R7: After a shutdown, no other port shuts down during the next OFF_HOLD_CYC edges. The earliest further shutdown happens OFF_HOLD_CYC+1 edges after the first one.
- R8: When `emerg_off` is high at an edge, all `pwr_en` bits are 0 after that edge, even inside a shutdown window. While it stays high, no port powers up.
- R9: A `pgood` bit becomes 1 after PG_QUAL_CYC consecutive edges at which the port is enabled and its `out_good` bit is high. It is still 0 after PG_QUAL_CYC-1 such edges.
- R10: A `pgood` bit is 0 in any cycle where its `out_good` bit is 0. It is also 0 once the port is switched off.
- R11: A `pwr_chg` bit sets on every power-up or power-down of its port, and it stays set until a `chg_clr` strobe for that port. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_req | input | NPORTS | Per-port turn-on request (detection and classification passed) |
| off_req | input | NPORTS | Per-port turn-off control |
| out_good | input | NPORTS | Per-port output voltage good indication |
| auto_chk_en | input | 1 | Enables the oscillator check before power-up |
| osc_fail | input | 1 | Oscillator failure indication |
| emerg_off | input | 1 | Emergency shutdown of all ports |
| chg_clr | input | NPORTS | Clear-on-read strobe for the change flags |
| pwr_en | output | NPORTS | Per-port power enable |
| pgood | output | NPORTS | Per-port qualified power-good status |
| pwr_chg | output | NPORTS | Per-port sticky power-change flag |

## Verification
Some properties are checked by assertions on every cycle. These are: at most one port switches per edge outside an emergency, any power-up happened with the on-timer idle and the oscillator check clear, any ordinary shutdown happened with the off-window idle, and an emergency leaves every port off. The assertions also check that each enable change is mirrored in the change flags and that the arbiter's grant is one-hot and lowest-index. Other behaviour can only be shown by the directed scenarios in the bench: the exact edge on which a held request is served after a hold-off, the qualification count of power-good, the clearing of the change flags and the recovery after an emergency.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_UP   = 2'd1,
        XF_DOWN = 2'd2
    } xfer_e;

    typedef struct packed {
        xfer_e      kind;
        logic [7:0] port;
    } xfer_t;

    function automatic int cnt_bits(input int limit);
        if (limit < 2) return 1;
        return $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/pwrseq_holdoff.sv
module pwrseq_holdoff
    import pwrseq_pkg::*;
#(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic idle
);
    localparam int CW = cnt_bits(CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle = (cnt_q == '0);

    generate
        if (CYC > 0) begin : g_chk
            AST_HOLD_ARMED: assert property (@(posedge clk) disable iff (rst)
                start |=> !idle)
                else $error("hold-off not armed after start"); // R4
        end
    endgenerate

endmodule

// File: rtl/pwrseq_arb.sv
module pwrseq_arb
    import pwrseq_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] up_ok,
    input  logic [NPORTS-1:0] down_ok,
    output xfer_t             xfer,
    output logic [NPORTS-1:0] gnt
);
    logic       up_any, down_any;
    logic [7:0] up_sel, down_sel;

    always_comb begin
        up_any   = 1'b0;
        down_any = 1'b0;
        up_sel   = '0;
        down_sel = '0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            if (up_ok[i]) begin
                up_any = 1'b1;
                up_sel = 8'(i);
            end
            if (down_ok[i]) begin
                down_any = 1'b1;
                down_sel = 8'(i);
            end
        end
    end

    always_comb begin
        xfer.kind = XF_IDLE;
        xfer.port = '0;
        if (down_any) begin
            xfer.kind = XF_DOWN;
            xfer.port = down_sel;
        end else if (up_any) begin
            xfer.kind = XF_UP;
            xfer.port = up_sel;
        end
    end

    always_comb begin
        gnt = '0;
        for (int i = 0; i < NPORTS; i++) begin
            gnt[i] = (xfer.kind != XF_IDLE) && (xfer.port == 8'(i));
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt))
        else $error("more than one grant"); // R3

    AST_GNT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (xfer.kind == XF_UP) |-> (((gnt - 1'b1) & up_ok) == '0))
        else $error("grant skipped a lower port"); // R3

    AST_GNT_VALID: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~(up_ok | down_ok)) == '0)
        else $error("grant without eligibility"); // R2

endmodule

// File: rtl/pwrseq_pgood.sv
module pwrseq_pgood
    import pwrseq_pkg::*;
#(
    parameter int QUAL = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic good,
    output logic pg
);
    localparam int CW = cnt_bits(QUAL);

    logic [CW-1:0] cnt_q;
    logic          pg_q;

    always_ff @(posedge clk) begin
        if (rst || !(en && good)) begin
            cnt_q <= '0;
            pg_q  <= 1'b0;
        end else begin
            if (int'(cnt_q) < QUAL) cnt_q <= cnt_q + 1'b1;
            if (int'(cnt_q) + 1 >= QUAL) pg_q <= 1'b1;
        end
    end

    assign pg = pg_q & good & en;

    AST_PG_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_q) |-> $past(en && good))
        else $error("power-good rose without qualification"); // R9

    AST_PG_DROPS: assert property (@(posedge clk) disable iff (rst)
        $fell(good) |=> !pg_q)
        else $error("power-good held after output-good fell"); // R10

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int NPORTS       = 4,
    parameter int ON_HOLD_CYC  = 1000,
    parameter int OFF_HOLD_CYC = 125000,
    parameter int PG_QUAL_CYC  = 2500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] on_req,
    input  logic [NPORTS-1:0] off_req,
    input  logic [NPORTS-1:0] out_good,
    input  logic              auto_chk_en,
    input  logic              osc_fail,
    input  logic              emerg_off,
    input  logic [NPORTS-1:0] chg_clr,
    output logic [NPORTS-1:0] pwr_en,
    output logic [NPORTS-1:0] pgood,
    output logic [NPORTS-1:0] pwr_chg
);
    logic [NPORTS-1:0] en_q, chg_q;
    logic [NPORTS-1:0] up_ok, down_ok, gnt;
    logic              on_idle, off_idle, osc_block;
    xfer_t             xfer;

    assign osc_block = auto_chk_en & osc_fail;

    always_comb begin
        for (int i = 0; i < NPORTS; i++) begin
            up_ok[i]   = on_req[i] & ~off_req[i] & ~en_q[i] & on_idle
                         & ~osc_block & ~emerg_off;
            down_ok[i] = off_req[i] & en_q[i] & off_idle & ~emerg_off;
        end
    end

    pwrseq_arb #(.NPORTS(NPORTS)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .up_ok   (up_ok),
        .down_ok (down_ok),
        .xfer    (xfer),
        .gnt     (gnt)
    );

    pwrseq_holdoff #(.CYC(ON_HOLD_CYC)) u_on_hold (
        .clk   (clk),
        .rst   (rst),
        .start (xfer.kind == XF_UP),
        .idle  (on_idle)
    );

    pwrseq_holdoff #(.CYC(OFF_HOLD_CYC)) u_off_hold (
        .clk   (clk),
        .rst   (rst),
        .start (xfer.kind == XF_DOWN),
        .idle  (off_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            chg_q <= '0;
        end else if (emerg_off) begin
            en_q  <= '0;
            chg_q <= (chg_q & ~chg_clr) | en_q;
        end else begin
            unique case (xfer.kind)
                XF_UP:   en_q <= en_q | gnt;
                XF_DOWN: en_q <= en_q & ~gnt;
                default: en_q <= en_q;
            endcase
            chg_q <= (chg_q & ~chg_clr) | gnt;
        end
    end

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            pwrseq_pgood #(.QUAL(PG_QUAL_CYC)) u_pg (
                .clk  (clk),
                .rst  (rst),
                .en   (en_q[p]),
                .good (out_good[p]),
                .pg   (pgood[p])
            );
        end
    endgenerate

    assign pwr_en  = en_q;
    assign pwr_chg = chg_q;

    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (rst)
        !$past(emerg_off) |-> ($countones(pwr_en ^ $past(pwr_en)) <= 1))
        else $error("two ports switched together"); // R3

    AST_UP_SPACED: assert property (@(posedge clk) disable iff (rst)
        ((pwr_en & ~$past(pwr_en)) != '0) |-> $past(on_idle))
        else $error("power-up inside on hold-off"); // R4

    AST_UP_OSC_OK: assert property (@(posedge clk) disable iff (rst)
        ((pwr_en & ~$past(pwr_en)) != '0) |-> !$past(auto_chk_en && osc_fail))
        else $error("power-up with oscillator failure"); // R5

    AST_DOWN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(emerg_off) && ((~pwr_en & $past(pwr_en)) != '0)) |-> $past(off_idle))
        else $error("shutdown inside off window"); // R7

    AST_EMERG_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(emerg_off) |-> (pwr_en == '0))
        else $error("port on after emergency"); // R8

    AST_CHG_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (((pwr_en ^ $past(pwr_en)) & ~pwr_chg) == '0))
        else $error("change flag missed a transition"); // R11

endmodule

// File: tb/pwrseq_ctrl_bench.sv
`timescale 1ns/1ps
module pwrseq_ctrl_bench;

    localparam int N   = 4;
    localparam int ONH = 4;
    localparam int OFH = 5;
    localparam int PGQ = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] on_req = '0, off_req = '0, out_good = '0, chg_clr = '0;
    logic         auto_chk_en = 1'b0, osc_fail = 1'b0, emerg_off = 1'b0;
    logic [N-1:0] pwr_en, pgood, pwr_chg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwrseq_ctrl #(
        .NPORTS(N), .ON_HOLD_CYC(ONH), .OFF_HOLD_CYC(OFH), .PG_QUAL_CYC(PGQ)
    ) u_pwrseq_ctrl (
        .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req),
        .out_good(out_good), .auto_chk_en(auto_chk_en), .osc_fail(osc_fail),
        .emerg_off(emerg_off), .chg_clr(chg_clr),
        .pwr_en(pwr_en), .pgood(pgood), .pwr_chg(pwr_chg)
    );

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 pwr_en in reset", pwr_en, '0);
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 pwr_en after reset", pwr_en, '0);
        check("R1 pgood after reset", pgood, '0);
        check("R1 pwr_chg after reset", pwr_chg, '0);
    endtask

    task automatic t_priority_spacing();
        on_req = 4'b1110;
        tick(1);
        check("R3 lowest port first", pwr_en, 4'b0010);
        tick(ONH);
        check("R4 no power-up inside hold-off", pwr_en, 4'b0010);
        tick(1);
        check("R4 next port after hold-off", pwr_en, 4'b0110);
        tick(ONH + 1);
        check("R2 third port powered", pwr_en, 4'b1110);
        on_req = '0;
        check("R11 change flags after power-ups", pwr_chg, 4'b1110);
    endtask

    task automatic t_pgood();
        out_good = 4'b0010;
        tick(PGQ - 1);
        check("R9 pgood not yet qualified", pgood, 4'b0000);
        tick(1);
        check("R9 pgood qualified", pgood, 4'b0010);
        out_good = 4'b0000;
        #1;
        check("R10 pgood drops with out_good", pgood, 4'b0000);
        @(negedge clk);
        out_good = 4'b0010;
        tick(1);
        check("R9 pgood requalifies from zero", pgood, 4'b0000);
        tick(PGQ - 1);
        check("R9 pgood requalified", pgood, 4'b0010);
    endtask

    task automatic t_chg_clear();
        chg_clr = 4'b0110;
        tick(1);
        chg_clr = '0;
        check("R11 partial clear", pwr_chg, 4'b1000);
        chg_clr = 4'b1000;
        tick(1);
        chg_clr = '0;
        check("R11 full clear", pwr_chg, 4'b0000);
    endtask

    task automatic t_off_window();
        off_req = 4'b1110;
        tick(1);
        check("R6 off request clears enable", pwr_en, 4'b1100);
        check("R10 pgood cleared on shutdown", pgood, 4'b0000);
        tick(OFH);
        check("R7 no shutdown inside window", pwr_en, 4'b1100);
        tick(1);
        check("R7 next shutdown after window", pwr_en, 4'b1000);
        off_req = '0;
        check("R11 change flags after shutdowns", pwr_chg, 4'b0110);
        out_good = '0;
    endtask

    task automatic t_off_over_on();
        on_req  = 4'b0001;
        off_req = 4'b0001;
        tick(3);
        check("R6 off request holds unpowered port off", pwr_en, 4'b1000);
        on_req  = '0;
        off_req = '0;
        tick(OFH + 2);
    endtask

    task automatic t_osc();
        auto_chk_en = 1'b1;
        osc_fail    = 1'b1;
        on_req      = 4'b0001;
        tick(6);
        check("R5 oscillator failure blocks power-up", pwr_en, 4'b1000);
        auto_chk_en = 1'b0;
        tick(1);
        check("R5 osc_fail ignored when check disabled", pwr_en, 4'b1001);
        osc_fail = 1'b0;
        on_req   = '0;
        chg_clr  = 4'b1111;
        tick(1);
        chg_clr  = '0;
        check("R11 flags cleared before emergency", pwr_chg, 4'b0000);
    endtask

    task automatic t_emergency();
        off_req = 4'b0001;
        tick(1);
        off_req = '0;
        check("R6 port 1 off, window open", pwr_en, 4'b1000);
        emerg_off = 1'b1;
        on_req    = 4'b1111;
        tick(1);
        check("R8 emergency overrides window", pwr_en, 4'b0000);
        check("R11 flags after emergency", pwr_chg, 4'b1001);
        tick(6);
        check("R8 no power-up during emergency", pwr_en, 4'b0000);
        emerg_off = 1'b0;
        tick(1);
        check("R2 power-up resumes after emergency", pwr_en, 4'b0001);
        on_req = '0;
    endtask

    initial begin
        t_reset();
        t_priority_spacing();
        t_pgood();
        t_chg_clear();
        t_off_window();
        t_off_over_on();
        t_osc();
        t_emergency();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule